// File: doc/BRIEF.md
# Sleep State and Power Button Controller

This block holds the platform's current sleep state and drives three active-low power-plane enables from it. Its inputs are a raw power button, a thermal-trip alarm, a modem ring line and a sleep-entry request from software. The button is debounced against a slow tick. A debounced press is a sleep request while the system is on and a wake event while it sleeps. A press held long enough forces soft-off. A thermal trip forces soft-off at once, without any processor handshake.

The sleep request goes out as a one-cycle pulse to the interrupt-routing logic, which is outside this block. Wake events go out as a separate one-cycle pulse. The ring-wake enable bit is on the resume reset, so it keeps its value when the core reset is applied. All durations are counts of the `tick` input, so one tick period sets the time scale of both the debounce and the override.

Top module: `slpctl_top`

## Requirements
- R1: The button press is accepted only after the synchronized, pressed level has been seen on DEB_TICKS consecutive ticks. A shorter low pulse causes no pulse and no state change.
- R2: An accepted press while the state is on (code 0) raises `sleep_evt_o` for one cycle and leaves the state at on. `sleep_evt_o` and `wake_evt_o` are never high together.
- R3: An accepted press in any sleep state (codes 1, 3, 4, 5) raises `wake_evt_o` for one cycle and returns the state to on.
- R4: When the button stays accepted-pressed for LONG_TICKS further ticks, the state becomes soft-off (code 5) from any state. This override fires once per press.
- R5: After an override the button does not wake the system while it stays held. Only a release followed by a new accepted press wakes it.
- R6: A low on `therm_trip_n` puts the state into soft-off on the third rising edge after it is applied (two synchronizer stages, then the state register). No pulse is produced, and while the low persists the state cannot leave soft-off.
- R7: `state_o` encodes on=0, light sleep=1, suspend-to-RAM=3, suspend-to-disk=4, soft-off=5. `plane_ram_n` is low in 3, 4 and 5. `plane_disk_n` is low in 4 and 5. `plane_off_n` is low only in 5.
- R8: A one-cycle `sw_sleep_req` moves the state to `sw_sleep_code` only when the state is on and the code is 1, 3, 4 or 5. Codes 0, 2, 6 and 7, and any request made while asleep, are ignored.
- R9: With the ring-wake enable set, a low on `ring_n` (after synchronization) while asleep raises `wake_evt_o` and returns the state to on. With the enable clear, `ring_n` has no effect.
- R10: The ring-wake enable is written by `ring_en_we`/`ring_en_d`. It is cleared only by `rsm_rst_n` and keeps its value through `rst_n`.
- R11: While and after `rst_n` is low, the state is on, both pulses are low and all plane enables are high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Core reset, active low, asynchronous |
| rsm_rst_n | input | 1 | Resume reset for the ring-wake enable, active low |
| tick | input | 1 | Slow time-base strobe, one clock wide, synchronous |
| pwr_btn_n | input | 1 | Raw power button, low when pressed, asynchronous |
| therm_trip_n | input | 1 | Thermal trip alarm, low active, asynchronous |
| ring_n | input | 1 | Modem ring line, low active, asynchronous |
| ring_en_we | input | 1 | Write strobe for the ring-wake enable |
| ring_en_d | input | 1 | Value written to the ring-wake enable |
| sw_sleep_req | input | 1 | Software sleep-entry strobe |
| sw_sleep_code | input | 3 | Target state code for the software request |
| state_o | output | 3 | Current sleep state code |
| sleep_evt_o | output | 1 | One-cycle sleep-request pulse |
| wake_evt_o | output | 1 | One-cycle wake pulse |
| plane_ram_n | output | 1 | Non-critical plane enable, low in 3/4/5 |
| plane_disk_n | output | 1 | Memory plane enable, low in 4/5 |
| plane_off_n | output | 1 | Soft-off plane enable, low in 5 |

## Verification
The properties assume that `sw_sleep_req` and `tick` are one-clock strobes synchronous to `clk`. They also assume that the three asynchronous lines change no faster than the synchronizer can follow, so every level seen by the state machine has been stable for at least one clock. The stimulus changes the button, ring and thermal inputs only on falling clock edges. It holds each level for several clocks and spaces button activity by more than the debounce window, except in the deliberate short-glitch case. The resume reset and the core reset are pulsed separately, each across at least one rising edge, so that their different effects on the ring enable can be told apart.

// File: rtl/slpctl_pkg.sv
package slpctl_pkg;

  typedef enum logic [2:0] {
    ST_ON   = 3'd0,
    ST_STBY = 3'd1,
    ST_RAM  = 3'd3,
    ST_DISK = 3'd4,
    ST_OFF  = 3'd5
  } pstate_e;

  // Plane enables, active low, packed as {off_n, disk_n, ram_n}
  function automatic logic [2:0] plane_ctl_n(pstate_e s);
    logic [2:0] r;
    r = 3'b111;
    if (s == ST_RAM || s == ST_DISK || s == ST_OFF) r[0] = 1'b0;
    if (s == ST_DISK || s == ST_OFF)                r[1] = 1'b0;
    if (s == ST_OFF)                                r[2] = 1'b0;
    return r;
  endfunction

  // Software may request only the defined sleep codes
  function automatic logic code_ok(logic [2:0] c);
    return (c == 3'd1) || (c == 3'd3) || (c == 3'd4) || (c == 3'd5);
  endfunction

  function automatic logic asleep(pstate_e s);
    return s != ST_ON;
  endfunction

endpackage

// File: rtl/slpctl_sync.sv
module slpctl_sync #(
  parameter int          W       = 1,
  parameter int          STAGES  = 2,
  parameter logic [W-1:0] RST_VAL = '1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] stg [STAGES];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < STAGES; i++) stg[i] <= RST_VAL;
    end else begin
      stg[0] <= d;
      for (int i = 1; i < STAGES; i++) stg[i] <= stg[i-1];
    end
  end

  assign q = stg[STAGES-1];
endmodule

// File: rtl/slpctl_debounce.sv
module slpctl_debounce #(
  parameter int DEB_TICKS  = 16,
  parameter int LONG_TICKS = 4000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic tick,
  input  logic btn_s,      // synchronized, low = pressed
  output logic press_now,  // accepted press edge
  output logic long_fire   // override event, once per press
);
  localparam int DW = $clog2(DEB_TICKS + 1);
  localparam int LW = $clog2(LONG_TICKS + 1);
  localparam logic [DW-1:0] DEB_LAST  = DW'(DEB_TICKS - 1);
  localparam logic [LW-1:0] LONG_LAST = LW'(LONG_TICKS - 1);

  logic          deb_q;    // 1 = released
  logic [DW-1:0] dcnt_q;
  logic [LW-1:0] hcnt_q;
  logic          fired_q;
  logic          accept;

  assign accept    = tick && (btn_s != deb_q) && (dcnt_q == DEB_LAST);
  assign press_now = accept && !btn_s;
  assign long_fire = tick && !deb_q && !fired_q && (hcnt_q == LONG_LAST);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      deb_q  <= 1'b1;
      dcnt_q <= '0;
    end else if (btn_s == deb_q) begin
      dcnt_q <= '0;
    end else if (tick) begin
      if (accept) begin
        dcnt_q <= '0;
        deb_q  <= btn_s;
      end else begin
        dcnt_q <= dcnt_q + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hcnt_q  <= '0;
      fired_q <= 1'b0;
    end else if (deb_q) begin
      hcnt_q  <= '0;
      fired_q <= 1'b0;
    end else if (tick && !fired_q) begin
      if (long_fire) fired_q <= 1'b1;
      else           hcnt_q  <= hcnt_q + 1'b1;
    end
  end
endmodule

// File: rtl/slpctl_fsm.sv
module slpctl_fsm
  import slpctl_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       therm_s,
  input  logic       long_fire,
  input  logic       press_now,
  input  logic       ring_wake,
  input  logic       sw_req,
  input  logic [2:0] sw_code,
  output pstate_e    state_q,
  output logic       evt_q,
  output logic       wake_q
);
  pstate_e st_d;
  logic    evt_d, wake_d;

  always_comb begin
    st_d   = state_q;
    evt_d  = 1'b0;
    wake_d = 1'b0;
    if (!therm_s) begin
      st_d = ST_OFF;
    end else if (long_fire) begin
      st_d = ST_OFF;
    end else if (press_now) begin
      if (asleep(state_q)) begin
        wake_d = 1'b1;
        st_d   = ST_ON;
      end else begin
        evt_d = 1'b1;
      end
    end else if (ring_wake) begin
      wake_d = 1'b1;
      st_d   = ST_ON;
    end else if (sw_req && !asleep(state_q) && code_ok(sw_code)) begin
      st_d = pstate_e'(sw_code);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_ON;
      evt_q   <= 1'b0;
      wake_q  <= 1'b0;
    end else begin
      state_q <= st_d;
      evt_q   <= evt_d;
      wake_q  <= wake_d;
    end
  end
endmodule

// File: rtl/slpctl_top.sv
module slpctl_top
  import slpctl_pkg::*;
#(
  parameter int DEB_TICKS   = 16,
  parameter int LONG_TICKS  = 4000,
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       rsm_rst_n,
  input  logic       tick,
  input  logic       pwr_btn_n,
  input  logic       therm_trip_n,
  input  logic       ring_n,
  input  logic       ring_en_we,
  input  logic       ring_en_d,
  input  logic       sw_sleep_req,
  input  logic [2:0] sw_sleep_code,
  output logic [2:0] state_o,
  output logic       sleep_evt_o,
  output logic       wake_evt_o,
  output logic       plane_ram_n,
  output logic       plane_disk_n,
  output logic       plane_off_n
);
  logic    btn_s, therm_s, ring_s;
  logic    press_now, long_fire, ring_wake;
  logic    ring_en_q;
  pstate_e state_q;
  logic [2:0] planes;

  slpctl_sync #(.W(3), .STAGES(SYNC_STAGES), .RST_VAL(3'b111)) sync_i (
    .clk(clk), .rst_n(rst_n),
    .d({pwr_btn_n, therm_trip_n, ring_n}),
    .q({btn_s, therm_s, ring_s})
  );

  slpctl_debounce #(.DEB_TICKS(DEB_TICKS), .LONG_TICKS(LONG_TICKS)) deb_i (
    .clk(clk), .rst_n(rst_n), .tick(tick), .btn_s(btn_s),
    .press_now(press_now), .long_fire(long_fire)
  );

  // Resume-domain enable: untouched by the core reset
  always_ff @(posedge clk or negedge rsm_rst_n) begin
    if (!rsm_rst_n)      ring_en_q <= 1'b0;
    else if (ring_en_we) ring_en_q <= ring_en_d;
  end

  assign ring_wake = ring_en_q && !ring_s && asleep(state_q);

  slpctl_fsm fsm_i (
    .clk(clk), .rst_n(rst_n), .therm_s(therm_s), .long_fire(long_fire),
    .press_now(press_now), .ring_wake(ring_wake), .sw_req(sw_sleep_req),
    .sw_code(sw_sleep_code), .state_q(state_q), .evt_q(sleep_evt_o),
    .wake_q(wake_evt_o)
  );

  assign planes       = plane_ctl_n(state_q);
  assign plane_ram_n  = planes[0];
  assign plane_disk_n = planes[1];
  assign plane_off_n  = planes[2];
  assign state_o      = state_q;
endmodule

// File: rtl/slpctl_chk.sv
module slpctl_chk (
  input logic       clk,
  input logic       rst_n,
  input logic [2:0] state_o,
  input logic       sleep_evt_o,
  input logic       wake_evt_o,
  input logic       plane_ram_n,
  input logic       plane_disk_n,
  input logic       plane_off_n,
  input logic       therm_s,
  input logic       long_fire
);
  // R2
  sleep_evt_on_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sleep_evt_o |-> (state_o == 3'd0 && $past(state_o) == 3'd0));
  // R2
  pulse_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(sleep_evt_o && wake_evt_o));
  // R3
  wake_to_on_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wake_evt_o |-> (state_o == 3'd0 && $past(state_o) != 3'd0));
  // R4
  long_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    long_fire |=> state_o == 3'd5);
  // R6
  therm_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !therm_s |=> (state_o == 3'd5 && !wake_evt_o && !sleep_evt_o));
  // R7
  plane_nest_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!plane_off_n |-> !plane_disk_n) and (!plane_disk_n |-> !plane_ram_n));
  // R7
  plane_off_state_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !plane_off_n |-> state_o == 3'd5);
  // R8
  sleep_exit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(state_o) != 3'd0 && state_o != $past(state_o)) |-> (state_o == 3'd0 || state_o == 3'd5));
  // R8
  sleep_entry_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((state_o == 3'd1 || state_o == 3'd3 || state_o == 3'd4) && state_o != $past(state_o))
      |-> $past(state_o) == 3'd0);
endmodule

bind slpctl_top slpctl_chk chk_i (
  .clk(clk), .rst_n(rst_n), .state_o(state_o), .sleep_evt_o(sleep_evt_o),
  .wake_evt_o(wake_evt_o), .plane_ram_n(plane_ram_n), .plane_disk_n(plane_disk_n),
  .plane_off_n(plane_off_n), .therm_s(therm_s), .long_fire(long_fire)
);

// File: tb/slpctl_tb.sv
module slpctl_top_tb_top;
  localparam int DEB  = 4;
  localparam int LONG = 24;

  logic clk = 0, rst_n = 0, rsm_rst_n = 0, tick = 0;
  logic pwr_btn_n = 1, therm_trip_n = 1, ring_n = 1;
  logic ring_en_we = 0, ring_en_d = 0, sw_sleep_req = 0;
  logic [2:0] sw_sleep_code = 0;
  logic [2:0] state_o;
  logic sleep_evt_o, wake_evt_o, plane_ram_n, plane_disk_n, plane_off_n;

  int checks = 0, fails = 0, n_evt = 0, n_wake = 0;
  bit done = 0;

  always #4 clk = ~clk;
  always @(negedge clk) tick <= ~tick;

  slpctl_top #(.DEB_TICKS(DEB), .LONG_TICKS(LONG)) dut_i (
    .clk(clk), .rst_n(rst_n), .rsm_rst_n(rsm_rst_n), .tick(tick),
    .pwr_btn_n(pwr_btn_n), .therm_trip_n(therm_trip_n), .ring_n(ring_n),
    .ring_en_we(ring_en_we), .ring_en_d(ring_en_d), .sw_sleep_req(sw_sleep_req),
    .sw_sleep_code(sw_sleep_code), .state_o(state_o), .sleep_evt_o(sleep_evt_o),
    .wake_evt_o(wake_evt_o), .plane_ram_n(plane_ram_n), .plane_disk_n(plane_disk_n),
    .plane_off_n(plane_off_n)
  );

  // ---------------- behavioural reference ----------------
  int m_st, m_dc, m_hc;
  bit m_evt, m_wake, m_deb, m_fired, m_ren, m_press, m_fire;
  bit bq[2], tq[2], rq[2];
  string m_tag = "R11";

  always @(posedge clk or negedge rsm_rst_n)
    if (!rsm_rst_n) m_ren <= 0;
    else if (ring_en_we) m_ren <= ring_en_d;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_st = 0; m_evt = 0; m_wake = 0; m_deb = 1; m_dc = 0; m_hc = 0; m_fired = 0;
      bq = '{1, 1}; tq = '{1, 1}; rq = '{1, 1}; m_tag = "R11";
    end else begin
      m_press = 0; m_fire = 0;
      if (m_deb) begin m_hc = 0; m_fired = 0; end
      else if (tick && !m_fired) begin
        if (m_hc == LONG - 1) begin m_fire = 1; m_fired = 1; end else m_hc++;
      end
      if (bq[1] == m_deb) m_dc = 0;
      else if (tick) begin
        if (m_dc == DEB - 1) begin m_dc = 0; m_deb = bq[1]; m_press = !bq[1]; end
        else m_dc++;
      end
      m_evt = 0; m_wake = 0;
      if (!tq[1]) begin m_st = 5; m_tag = "R6"; end
      else if (m_fire) begin m_st = 5; m_tag = "R4"; end
      else if (m_press) begin
        if (m_st == 0) begin m_evt = 1; m_tag = "R2"; end
        else begin m_wake = 1; m_st = 0; m_tag = "R3"; end
      end else if (m_ren && !rq[1] && m_st != 0) begin m_wake = 1; m_st = 0; m_tag = "R9"; end
      else if (sw_sleep_req && m_st == 0 && sw_sleep_code inside {1, 3, 4, 5}) begin
        m_st = sw_sleep_code; m_tag = "R8";
      end
      bq[1] = bq[0]; bq[0] = pwr_btn_n;
      tq[1] = tq[0]; tq[0] = therm_trip_n;
      rq[1] = rq[0]; rq[0] = ring_n;
    end
  end

  function automatic logic [2:0] exp_planes(int s);
    case (s)
      3: return 3'b110;
      4: return 3'b100;
      5: return 3'b000;
      default: return 3'b111;
    endcase
  endfunction

  task automatic chk(bit ok, string req, int act, int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
    end
  endtask

  // every-cycle comparison against the model
  always @(negedge clk) if (rst_n && !done) begin
    if (sleep_evt_o) n_evt++;
    if (wake_evt_o) n_wake++;
    chk(state_o == m_st[2:0], m_tag, state_o, m_st);
    chk(sleep_evt_o == m_evt && wake_evt_o == m_wake, m_tag, {sleep_evt_o, wake_evt_o}, {m_evt, m_wake});
    chk({plane_off_n, plane_disk_n, plane_ram_n} == exp_planes(m_st), "R7",
        {plane_off_n, plane_disk_n, plane_ram_n}, exp_planes(m_st));
  end

  task automatic cyc(int n); repeat (n) @(negedge clk); endtask
  task automatic press(int hold); pwr_btn_n = 0; cyc(hold); pwr_btn_n = 1; cyc(24); endtask
  task automatic sw(int code);
    sw_sleep_req = 1; sw_sleep_code = 3'(code); cyc(1); sw_sleep_req = 0; cyc(2);
  endtask
  task automatic set_ren(bit v); ring_en_we = 1; ring_en_d = v; cyc(1); ring_en_we = 0; endtask

  task automatic summary;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual 1 expected 0");
    done = 1;
    summary();
    $finish;
  end

  initial begin
    int e0, w0;
    cyc(3);
    rsm_rst_n = 1; rst_n = 1;
    cyc(1);
    // R11 reset state
    chk(state_o == 0 && !sleep_evt_o && !wake_evt_o, "R11", state_o, 0);
    chk({plane_off_n, plane_disk_n, plane_ram_n} == 3'b111, "R11", plane_ram_n, 1);
    // R1 short glitch ignored
    e0 = n_evt; press(4);
    chk(n_evt == e0 && state_o == 0, "R1", n_evt - e0, 0);
    // R2 press while on
    e0 = n_evt; press(20);
    chk(n_evt == e0 + 1, "R2", n_evt - e0, 1);
    chk(state_o == 0, "R2", state_o, 0);
    // R8 invalid code, then valid, then request while asleep
    sw(2); chk(state_o == 0, "R8", state_o, 0);
    sw(0); chk(state_o == 0, "R8", state_o, 0);
    sw(3); chk(state_o == 3 && !plane_ram_n && plane_disk_n, "R8", state_o, 3);
    sw(5); chk(state_o == 3, "R8", state_o, 3);
    // R3 wake from suspend-to-RAM
    w0 = n_wake; press(20);
    chk(state_o == 0 && n_wake == w0 + 1, "R3", state_o, 0);
    sw(4); chk(state_o == 4 && !plane_disk_n && plane_off_n, "R7", state_o, 4);
    press(20); chk(state_o == 0, "R3", state_o, 0);
    // R9 ring with enable clear, then set
    sw(1); chk(state_o == 1 && plane_ram_n, "R7", state_o, 1);
    ring_n = 0; cyc(6); ring_n = 1; cyc(3);
    chk(state_o == 1, "R9", state_o, 1);
    set_ren(1);
    w0 = n_wake; ring_n = 0; cyc(4); ring_n = 1; cyc(3);
    chk(state_o == 0 && n_wake == w0 + 1, "R9", state_o, 0);
    // R3 wake from soft-off
    sw(5); chk(!plane_off_n, "R7", plane_off_n, 0);
    press(20); chk(state_o == 0, "R3", state_o, 0);
    // R4 long press from on, R5 held button does not wake
    w0 = n_wake; e0 = n_evt;
    pwr_btn_n = 0; cyc(80);
    chk(state_o == 5, "R4", state_o, 5);
    cyc(60);
    chk(state_o == 5 && n_wake == w0, "R5", n_wake - w0, 0);
    pwr_btn_n = 1; cyc(24);
    chk(state_o == 5, "R5", state_o, 5);
    press(20); chk(state_o == 0 && n_wake == w0 + 1, "R5", state_o, 0);
    // R4 long press from suspend-to-disk
    sw(4); pwr_btn_n = 0; cyc(80);
    chk(state_o == 5, "R4", state_o, 5);
    pwr_btn_n = 1; cyc(24); press(20);
    // R6 thermal trip timing
    chk(state_o == 0, "R6", state_o, 0);
    therm_trip_n = 0; cyc(2);
    chk(state_o == 0, "R6", state_o, 0);
    cyc(1);
    chk(state_o == 5, "R6", state_o, 5);
    ring_n = 0; cyc(4); ring_n = 1;
    chk(state_o == 5, "R6", state_o, 5);
    therm_trip_n = 1; cyc(4);
    press(20); chk(state_o == 0, "R3", state_o, 0);
    // R10 enable survives core reset
    rst_n = 0; cyc(2); rst_n = 1; cyc(1);
    chk(state_o == 0, "R11", state_o, 0);
    sw(3); ring_n = 0; cyc(4); ring_n = 1; cyc(3);
    chk(state_o == 0, "R10", state_o, 0);
    // R10 resume reset clears enable
    rsm_rst_n = 0; cyc(2); rsm_rst_n = 1;
    sw(3); ring_n = 0; cyc(6); ring_n = 1; cyc(3);
    chk(state_o == 3, "R10", state_o, 3);
    cyc(4);
    done = 1;
    summary();
    $finish;
  end
endmodule